// File: doc/BRIEF.md
# Cycle-Counted Pulse-Rejecting Delay Line

This block delays a single-bit signal by a fixed number of clock cycles. It can also drop short pulses before they reach the output, the way a gate with propagation delay would. It is built from two stages. The first is a glitch filter: its output copies the input only after the input has held a new level for a set number of consecutive samples. The second is a tapped shift register that adds the remaining cycles, so the total latency is always `DELAY`.

A two-bit mode input picks the filter threshold. Transport mode uses a threshold of zero, so every edge passes through. Inertial mode uses a threshold equal to the full delay. Reject-limited mode uses a threshold of `REJECT`, which may be shorter than the delay. The mode input is captured only while reset is held and stays frozen afterwards. Reset is asserted asynchronously and active-low, and it is released in step with the clock.

Top module: `pulse_delay_line`

## Requirements
- R1: With mode 2'b00 (transport), the value of `din` in clock cycle n appears on `dout` in cycle n+DELAY for every pulse width, including single-cycle pulses.
- R2: With mode 2'b01 (inertial), a pulse shorter than DELAY cycles never appears on `dout`. A pulse of DELAY cycles or more, with gaps of at least DELAY cycles on both sides, appears with its width unchanged, DELAY cycles later.
- R3: With mode 2'b10 (reject-limited), `dout` equals an inertial filter of threshold REJECT followed by a pure delay of DELAY−REJECT cycles. Pulses of REJECT cycles or more pass with total delay DELAY, and shorter pulses are removed.
- R4: The filter takes a new level only after `din` has shown that level for threshold-many consecutive samples. Any return to the old level before then restarts the count, so a sequence of short pulses separated by one-cycle gaps is removed.
- R5: Mode 2'b11 behaves exactly like transport mode.
- R6: While `rst_n` is low, every stage and `dout` are 0. Assertion of reset takes effect without waiting for a clock edge.
- R7: `mode_i` is sampled only while reset is in effect. Changing it after reset release has no effect on `dout`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronized inside |
| mode_i | input | 2 | Delay mode: 00 transport, 01 inertial, 10 reject-limited, 11 as transport |
| din | input | 1 | Signal to delay |
| dout | output | 1 | Delayed and filtered signal |

## Verification
The bench targets pulses just below, at and just above each threshold (REJECT−1, REJECT, DELAY−1, DELAY). An off-by-one in the filter counter would pass a pulse it should drop, or drop one it should pass. It also targets the zero-depth delay stage of inertial mode: a wrong tap there would add or lose a cycle of latency. Trains of short pulses split by one-cycle gaps catch a counter that fails to restart, which would let the train through as one long pulse. Changing the mode after release catches a design that reads the mode live.

// File: rtl/pdl_pkg.sv
package pdl_pkg;

  typedef enum logic [1:0] {
    PDL_TRANSPORT = 2'b00,
    PDL_INERTIAL  = 2'b01,
    PDL_LIMITED   = 2'b10,
    PDL_SPARE     = 2'b11
  } pdl_mode_e;

endpackage

// File: rtl/pdl_rst_sync.sv
module pdl_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_n;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_n = 1'b1;
    end else begin : g_multi
      always_comb chain_n = {chain_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_n;
    end
  end

  assign rst_q = chain_q[STAGES-1];

endmodule

// File: rtl/pdl_glitch_filter.sv
module pdl_glitch_filter #(
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          din,
  input  logic [CW-1:0] thr,
  output logic          y
);

  logic          y_q, y_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          bypass;
  logic          upd_en;

  always_comb begin
    bypass = (thr == '0);
    y_n    = y_q;
    cnt_n  = '0;
    if (bypass) begin
      y_n = din;
    end else if (din != y_q) begin
      if (cnt_q >= (thr - CW'(1))) begin
        y_n = din;
      end else begin
        cnt_n = cnt_q + CW'(1);
      end
    end
    upd_en = (y_n != y_q) || (cnt_n != cnt_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y_q   <= 1'b0;
      cnt_q <= '0;
    end else if (upd_en) begin
      y_q   <= y_n;
      cnt_q <= cnt_n;
    end
  end

  assign y = bypass ? din : y_q;

  AST_CNT_BELOW_THR: assert property (@(posedge clk) disable iff (!rst_n)
    (thr != '0) |-> (cnt_q < thr)); // R4

  AST_LEVEL_FROM_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(y_q) |-> (y_q == $past(din))); // R4

  AST_LEVEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ((thr >= CW'(2)) && !$stable(y_q)) |-> ($past(din, 2) == $past(din))); // R4

endmodule

// File: rtl/pdl_tap_delay.sv
module pdl_tap_delay #(
  parameter int unsigned DEPTH = 10,
  parameter int unsigned CW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          din,
  input  logic [CW-1:0] tap,
  output logic          dout
);

  logic [DEPTH-1:0] sr_q;
  logic [DEPTH-1:0] sr_n;

  generate
    if (DEPTH == 1) begin : g_one
      always_comb sr_n = din;
    end else begin : g_many
      always_comb sr_n = {sr_q[DEPTH-2:0], din};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else begin
      sr_q <= sr_n;
    end
  end

  always_comb begin
    dout = din;
    for (int i = 0; i < int'(DEPTH); i++) begin
      if (tap == CW'(i + 1)) dout = sr_q[i];
    end
  end

  AST_TAP_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (tap <= CW'(DEPTH))); // R1

endmodule

// File: rtl/pulse_delay_line.sv
module pulse_delay_line
  import pdl_pkg::*;
#(
  parameter int unsigned DELAY       = 10,
  parameter int unsigned REJECT      = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_i,
  input  logic       din,
  output logic       dout
);

  localparam int unsigned CW = $clog2(DELAY + 1);

  generate
    if (DELAY == 0 || REJECT > DELAY) begin : g_param_bad
      $error("pulse_delay_line: need DELAY >= 1 and REJECT <= DELAY");
    end
  endgenerate

  logic          rst_q;
  pdl_mode_e     mode_q, mode_n;
  logic          mode_en;
  logic [CW-1:0] thr;
  logic [CW-1:0] tap;
  logic          filt_y;

  pdl_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_q (rst_q)
  );

  always_comb begin
    mode_en = !rst_q;
    mode_n  = pdl_mode_e'(mode_i);
  end

  always_ff @(posedge clk) begin
    if (mode_en) mode_q <= mode_n;
  end

  always_comb begin
    unique case (mode_q)
      PDL_INERTIAL: thr = CW'(DELAY);
      PDL_LIMITED:  thr = CW'(REJECT);
      default:      thr = '0;
    endcase
    tap = CW'(DELAY) - thr;
  end

  pdl_glitch_filter #(.CW(CW)) u_filter (
    .clk   (clk),
    .rst_n (rst_q),
    .din   (din),
    .thr   (thr),
    .y     (filt_y)
  );

  pdl_tap_delay #(.DEPTH(DELAY), .CW(CW)) u_delay (
    .clk   (clk),
    .rst_n (rst_q),
    .din   (filt_y),
    .tap   (tap),
    .dout  (dout)
  );

  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_q)
    $past(rst_q) |-> $stable(mode_q)); // R7

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_q |-> (dout == 1'b0)); // R6

  AST_THR_WITHIN_DELAY: assert property (@(posedge clk) disable iff (!rst_q)
    (thr <= CW'(DELAY))); // R3

endmodule

// File: tb/pulse_delay_line_bench.sv
module pulse_delay_line_bench;

  localparam int CLK_PERIOD = 10;
  localparam int D  = 10;
  localparam int RJ = 4;
  localparam int HN = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode_i = 2'b00;
  logic       din = 1'b0;
  logic       dout;

  int    checks = 0;
  int    fails = 0;
  int    cyc = 0;
  int    thr_m = 0;
  string tag = "R6";
  bit    hist [HN];
  bit    yref [HN];

  always #(CLK_PERIOD/2) clk = ~clk;

  pulse_delay_line #(.DELAY(D), .REJECT(RJ)) u_pulse_delay_line (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode_i (mode_i),
    .din    (din),
    .dout   (dout)
  );

  function automatic int thr_of(int m);
    if (m == 1) return D;
    if (m == 2) return RJ;
    return 0;
  endfunction

  function automatic bit filt_ref(int c);
    bit cand;
    if (thr_m == 0) return hist[c % HN];
    cand = hist[(c - 1) % HN];
    for (int k = 1; k <= thr_m; k++) begin
      if (hist[(c - k) % HN] != cand) return yref[(c - 1) % HN];
    end
    return cand;
  endfunction

  task automatic check(bit act, bit exp, string t);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: dout=%0b expected %0b (cycle %0d)", t, act, exp, cyc);
    end
  endtask

  task automatic step(bit v);
    @(negedge clk);
    din = v;
    cyc++;
    hist[cyc % HN] = v;
    yref[cyc % HN] = filt_ref(cyc);
    check(dout, yref[(cyc - (D - thr_m)) % HN], tag);
  endtask

  task automatic pulse(bit lvl, int width, int gap);
    for (int i = 0; i < width; i++) step(lvl);
    for (int i = 0; i < gap; i++) step(!lvl);
  endtask

  task automatic run_phase(int m, string mtag);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(dout, 1'b0, "R6");
    mode_i = 2'(m);
    din = 1'b0;
    repeat (3) begin
      @(negedge clk);
      check(dout, 1'b0, "R6");
    end
    for (int i = 0; i < HN; i++) begin
      hist[i] = 1'b0;
      yref[i] = 1'b0;
    end
    cyc = 2 * HN;
    thr_m = thr_of(m);
    tag = mtag;
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) step(1'b0);
    mode_i = 2'(m ^ 1);  // R7: late change must be ignored
    // boundary widths around both thresholds
    pulse(1'b1, 1, D + 3);
    pulse(1'b1, 2, D + 3);
    pulse(1'b1, RJ - 1, D + 3);
    pulse(1'b1, RJ, D + 3);
    pulse(1'b1, RJ + 1, D + 3);
    pulse(1'b1, D - 1, D + 3);
    pulse(1'b1, D, D + 3);
    pulse(1'b1, D + 1, D + 3);
    // low glitches inside a long high level
    for (int i = 0; i < 2 * D; i++) step(1'b1);
    pulse(1'b0, RJ - 1, 2 * D);
    pulse(1'b0, RJ, 2 * D);
    for (int i = 0; i < D + 3; i++) step(1'b0);
    // R4: near-threshold pulse trains with one-cycle gaps restart the count
    tag = {mtag, " R4"};
    for (int r = 0; r < 3; r++) pulse(1'b1, RJ - 1, 1);
    for (int i = 0; i < D + 3; i++) step(1'b0);
    for (int r = 0; r < 3; r++) pulse(1'b1, D - 1, 1);
    for (int i = 0; i < D + 3; i++) step(1'b0);
    tag = mtag;
    // random run lengths
    begin
      bit lvl = 1'b0;
      for (int r = 0; r < 60; r++) begin
        int len = int'($urandom_range(1, D + 3));
        lvl = !lvl;
        for (int i = 0; i < len; i++) step(lvl);
      end
    end
    // fill with ones, then reset asynchronously mid-stream
    for (int i = 0; i < 2 * D + 2; i++) step(1'b1);
    check(dout, 1'b1, mtag);
    #1;
    rst_n = 1'b0;
    #1;
    check(dout, 1'b0, "R6");
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(dout, 1'b0, "R6");
    run_phase(0, "R1 R7");
    run_phase(1, "R2 R7");
    run_phase(2, "R3 R7");
    run_phase(3, "R5 R7");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not end (actual hung, expected finish)");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule